// File: doc/BRIEF.md
# Rate-Scanning Frequency Acquisition Sequencer

This block is the slow-clock controller that helps a clock-recovery loop pull in to an incoming serial stream. It drives a digital frequency-control code for the oscillator. Each acquisition cycle ramps the code from the bottom to the top of a band centred on a nominal value, then ramps it back down to the bottom. When a cycle ends without lock and the block is in auto mode, a 2-bit rate counter steps on. The counter picks the divider modulus and the oscillator curve that the next cycle tries.

With the standard-rate select high, the scan visits all four rate codes. With it low, only two distinct moduli exist, so the scan alternates between them. In manual mode the rate code comes from an input, and the counter is neither advanced nor driven out. The sweep and the counter freeze while the loop reports lock or while no input data is present. A new acquisition therefore resumes at the last good rate, restarting its ramp from the bottom of the band.

Top module: `rate_scan_seq`

## Requirements
- R1: While reset is held, the sweep code equals BAND_LO (CENTER - HALF_SPAN) and rate_out is 0. After reset the first cycle starts ramping up from BAND_LO.
- R2: During the up ramp, the code takes each value from BAND_LO to BAND_HI (CENTER + HALF_SPAN) in turn. It holds each value for exactly DWELL clocks.
- R3: After BAND_HI, the code falls through BAND_HI-1 down to BAND_LO, holding each value for DWELL clocks. It then stays at BAND_LO for one more clock, so one cycle lasts (2N-1)*DWELL+1 clocks, where N = 2*HALF_SPAN+1.
- R4: In auto mode with std_sel=1, the rate counter advances by one, modulo 4, on the clock that ends each completed cycle. It changes at no other time.
- R5: In auto mode with std_sel=0, the rate counter toggles only its bit 1 at the end of each completed cycle.
- R6: In manual mode (auto_mode=0), rate_in selects the modulus and curve, and the rate counter is never advanced.
- R7: With std_sel=1, div_mod encodes the modulus as its value: rate code 00 gives 4, 01 and 10 give 2, and 11 gives 1.
- R8: With std_sel=0, rate codes 00 and 01 give div_mod=4, and 10 and 11 give div_mod=2.
- R9: curve_low is 1 only when std_sel=1 and bit 0 of the selected rate code is 1.
- R10: While lock=1, the sweep code and the rate counter keep their values. On the first clock with lock=0 and data present, the code returns to BAND_LO and a fresh up ramp begins.
- R11: While data_present=0, the code and the rate counter are frozen in the same way. A cycle interrupted at its last clock does not advance the counter.
- R12: rate_out always shows the rate counter, and rate_drive equals auto_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 = scan rates automatically, 0 = rate taken from rate_in |
| std_sel | input | 1 | 1 = four-rate standard set, 0 = two-modulus set |
| rate_in | input | 2 | Manual rate code |
| data_present | input | 1 | Input transitions are being seen |
| lock | input | 1 | Loop reports phase lock |
| sweep_code | output | CODE_W | Oscillator frequency-control code |
| div_mod | output | 3 | Divider modulus as a value (1, 2 or 4) |
| curve_low | output | 1 | Select the low oscillator curve |
| rate_out | output | 2 | Current rate counter |
| rate_drive | output | 1 | Rate pins are driven by the block (auto mode) |

## Verification
The bench builds the block with a 6-bit code, CENTER=20, HALF_SPAN=3 and DWELL=2. These values make one acquisition cycle 27 clocks long, so many full cycles fit in a short run. The counter wraps through all four codes several times, and toggles under the two-modulus set, within a few hundred clocks. The short cycle also makes it cheap to place lock drops and data losses on every phase of the ramp, including the single advance clock at the bottom of the band.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    SW_UP   = 2'd0,
    SW_DOWN = 2'd1,
    SW_ADV  = 2'd2,
    SW_HOLD = 2'd3
  } sweep_st_e;

  // Divider modulus, encoded as its numeric value.
  function automatic logic [2:0] div_of(input logic std, input logic [1:0] sel);
    logic [2:0] d;
    if (std) begin
      if (sel == 2'b00)      d = 3'd4;
      else if (sel == 2'b11) d = 3'd1;
      else                   d = 3'd2;
    end else begin
      d = sel[1] ? 3'd2 : 3'd4;
    end
    return d;
  endfunction

  function automatic logic curve_low_of(input logic std, input logic [1:0] sel);
    return std & sel[0];
  endfunction

  // Next rate code after a failed cycle.
  function automatic logic [1:0] next_rate(input logic std, input logic [1:0] cur);
    logic [1:0] n;
    if (std) n = cur + 2'd1;
    else     n = {~cur[1], cur[0]};
    return n;
  endfunction

endpackage

// File: rtl/rsq_dwell_timer.sv
module rsq_dwell_timer #(
  parameter int DWELL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [TW-1:0] LAST = TW'(DWELL - 1);

  logic [TW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: the dwell count never passes its last value
  p_dwell_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R10: a stopped timer restarts from zero
  p_dwell_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/rsq_sweep_ctrl.sv
module rsq_sweep_ctrl
  import rsq_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int BAND_LO = 115,
  parameter int BAND_HI = 141
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              halt,
  output logic [CODE_W-1:0] code,
  output logic              sweeping,
  output logic              cycle_done
);
  localparam logic [CODE_W-1:0] LO_C = CODE_W'(BAND_LO);
  localparam logic [CODE_W-1:0] HI_C = CODE_W'(BAND_HI);

  sweep_st_e         st_q;
  logic [CODE_W-1:0] code_q;

  assign code       = code_q;
  assign sweeping   = ((st_q == SW_UP) || (st_q == SW_DOWN)) && !halt;
  assign cycle_done = (st_q == SW_ADV) && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_UP;
      code_q <= LO_C;
    end else if (halt) begin
      st_q <= SW_HOLD;
    end else begin
      case (st_q)
        SW_UP: if (tick) begin
          if (code_q == HI_C) begin
            st_q   <= SW_DOWN;
            code_q <= code_q - 1'b1;
          end else begin
            code_q <= code_q + 1'b1;
          end
        end
        SW_DOWN: if (tick) begin
          if (code_q == LO_C) st_q <= SW_ADV;
          else                code_q <= code_q - 1'b1;
        end
        SW_ADV:  st_q <= SW_UP;
        default: begin
          st_q   <= SW_UP;
          code_q <= LO_C;
        end
      endcase
    end
  end

  // R2: the code stays inside the band
  p_in_band_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q >= LO_C) && (code_q <= HI_C));

  // R2: during the up ramp the code moves only on a dwell tick
  p_up_dwell_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SW_UP) && !halt && !tick |=> $stable(code_q));

  // R3: the advance clock sits at the band bottom
  p_adv_at_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SW_ADV) |-> code_q == LO_C);

  // R10: a halted sweep keeps its code
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> code_q == $past(code_q));

  // R10: leaving hold restarts from the band bottom
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SW_HOLD) && !halt |=> code_q == LO_C);

endmodule

// File: rtl/rsq_rate_ctr.sv
module rsq_rate_ctr
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  input  logic       std_sel,
  output logic [1:0] rate_cnt
);
  logic [1:0] cnt_q;

  assign rate_cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= 2'd0;
    else if (advance) cnt_q <= next_rate(std_sel, cnt_q);
  end

  // R11: without an advance pulse the counter is latched
  p_latched_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(cnt_q));

  // R4: standard set steps by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance && std_sel |=> cnt_q == 2'($past(cnt_q) + 2'd1));

  // R5: two-modulus set toggles bit 1 only
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !std_sel |=> cnt_q == ($past(cnt_q) ^ 2'b10));

endmodule

// File: rtl/rsq_rate_map.sv
module rsq_rate_map
  import rsq_pkg::*;
(
  input  logic       auto_mode,
  input  logic       std_sel,
  input  logic [1:0] rate_in,
  input  logic [1:0] rate_cnt,
  output logic [2:0] div_mod,
  output logic       curve_low,
  output logic [1:0] rate_out,
  output logic       rate_drive
);
  logic [1:0] sel;

  always_comb begin
    sel        = auto_mode ? rate_cnt : rate_in;
    div_mod    = div_of(std_sel, sel);
    curve_low  = curve_low_of(std_sel, sel);
    rate_out   = rate_cnt;
    rate_drive = auto_mode;
  end

endmodule

// File: rtl/rate_scan_seq.sv
module rate_scan_seq #(
  parameter int CODE_W    = 8,
  parameter int CENTER    = 128,
  parameter int HALF_SPAN = 13,
  parameter int DWELL     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_mode,
  input  logic              std_sel,
  input  logic [1:0]        rate_in,
  input  logic              data_present,
  input  logic              lock,
  output logic [CODE_W-1:0] sweep_code,
  output logic [2:0]        div_mod,
  output logic              curve_low,
  output logic [1:0]        rate_out,
  output logic              rate_drive
);
  localparam int BAND_LO = CENTER - HALF_SPAN;
  localparam int BAND_HI = CENTER + HALF_SPAN;

  logic       halt;
  logic       tick;
  logic       sweeping;
  logic       cycle_done;
  logic       advance;
  logic [1:0] rate_cnt;

  assign halt    = lock || !data_present;
  assign advance = cycle_done && auto_mode;

  rsq_dwell_timer #(.DWELL(DWELL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (sweeping),
    .tick (tick)
  );

  rsq_sweep_ctrl #(
    .CODE_W (CODE_W),
    .BAND_LO(BAND_LO),
    .BAND_HI(BAND_HI)
  ) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .halt      (halt),
    .code      (sweep_code),
    .sweeping  (sweeping),
    .cycle_done(cycle_done)
  );

  rsq_rate_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .std_sel (std_sel),
    .rate_cnt(rate_cnt)
  );

  rsq_rate_map u_map (
    .auto_mode (auto_mode),
    .std_sel   (std_sel),
    .rate_in   (rate_in),
    .rate_cnt  (rate_cnt),
    .div_mod   (div_mod),
    .curve_low (curve_low),
    .rate_out  (rate_out),
    .rate_drive(rate_drive)
  );

  // R9: the low curve never pairs with the divide-by-4 setting
  p_curve_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    curve_low |-> div_mod != 3'd4);

  // R6: in manual mode the counter never moves
  p_manual_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |=> rate_out == $past(rate_out));

endmodule

// File: tb/rate_scan_seq_bench.sv
`timescale 1ns/1ps
module rate_scan_seq_bench;
  localparam int CW = 6;
  localparam int LO = 17;
  localparam int HI = 23;
  localparam int N  = HI - LO + 1;
  localparam int D  = 2;
  localparam int L  = (2 * N - 1) * D + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_mode = 1'b1, std_sel = 1'b1, data_present = 1'b1, lock = 1'b0;
  logic [1:0] rate_in = 2'd0;
  logic [CW-1:0] sweep_code;
  logic [2:0] div_mod;
  logic curve_low, rate_drive;
  logic [1:0] rate_out;

  int nchk = 0, nerr = 0;
  bit checking = 0, done = 0;

  always #2.5 clk = ~clk;

  rate_scan_seq #(.CODE_W(CW), .CENTER(20), .HALF_SPAN(3), .DWELL(D)) u_rate_scan_seq (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .std_sel(std_sel),
    .rate_in(rate_in), .data_present(data_present), .lock(lock),
    .sweep_code(sweep_code), .div_mod(div_mod), .curve_low(curve_low),
    .rate_out(rate_out), .rate_drive(rate_drive));

  // Reference model: position within a cycle, plus a frozen flag.
  int m_phase = 0, m_cnt = 0, m_frozen = LO;
  bit m_held = 0;

  function automatic int code_at(int p);
    if (p < N * D) return LO + p / D;
    if (p < (2 * N - 1) * D) return HI - 1 - (p - N * D) / D;
    return LO;
  endfunction

  function automatic int exp_mod(bit std, int c);
    if (std) begin
      case (c)
        0: return 4;
        3: return 1;
        default: return 2;
      endcase
    end
    return (c >= 2) ? 2 : 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_held = 0;
    end else if (lock || !data_present) begin
      if (!m_held) m_frozen = code_at(m_phase);
      m_held = 1;
    end else if (m_held) begin
      m_held = 0; m_phase = 0;
    end else if (m_phase == L - 1) begin
      m_phase = 0;
      if (auto_mode) m_cnt = std_sel ? (m_cnt + 1) % 4 : (m_cnt ^ 2);
    end else begin
      m_phase++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) begin
      int sel;
      sel = auto_mode ? m_cnt : int'(rate_in);
      chk(m_held ? "R10/R11 frozen code" : (m_phase < N * D ? "R2 up code" : "R3 down code"),
          int'(sweep_code), m_held ? m_frozen : code_at(m_phase));
      chk("R4/R5/R11/R12 rate_out", int'(rate_out), m_cnt);
      chk(!auto_mode ? "R6 manual div_mod" : (std_sel ? "R7 div_mod" : "R8 div_mod"),
          int'(div_mod), exp_mod(std_sel, sel));
      chk("R9 curve_low", int'(curve_low), (std_sel && (sel % 2 == 1)) ? 1 : 0);
      chk("R12 rate_drive", int'(rate_drive), int'(auto_mode));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got 0 expected 1 completion");
      finish_run();
    end
  end

  initial begin
    step(3);
    chk("R1 reset code", int'(sweep_code), LO);
    chk("R1 reset rate_out", int'(rate_out), 0);
    checking = 1;
    rst_n = 1'b1;
    step(5 * L + 5);                       // R4 wraps through all codes
    step(4); lock = 1'b1; step(20); lock = 1'b0;    // R10
    step(60);
    data_present = 1'b0; step(15); data_present = 1'b1; // R11
    step(40);
    std_sel = 1'b0; step(3 * L + 7);       // R5, R8
    auto_mode = 1'b0;                      // R6
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 2; t++) begin
        rate_in = 2'(s); std_sel = t[0]; step(6);
      end
    end
    step(2 * L);
    auto_mode = 1'b1; std_sel = 1'b1;
    for (int i = 0; i < 900; i++) begin
      lock = ((i % 53) < 3);
      data_present = !((i % 71) < 2);
      std_sel = ((i / 150) % 2) == 0;
      step(1);
    end
    lock = 1'b0; data_present = 1'b1;
    step(2 * L);
    done = 1;
    finish_run();
  end

endmodule